// File: doc/BRIEF.md
# Frame-Pulse One-Second Timer

This block turns the 8 kHz frame pulse of a 2.048 Mb/s serial backplane into two slow timing references. A controller uses them to pace periodic performance messages. The block is clocked by the backplane bit clock and counts only frame pulses. Every half second, which is 4000 frames, a square-wave output flips, so the square wave has a period of one second.

A second output, the timer status bit, flips once for each rising edge of the square wave, so its period is two seconds. The status bit does not flip together with the square wave. It flips a fixed number of bit clocks (62 by default) after the bit-clock edge that sampled the frame pulse which caused the square wave to rise. This gives the status bit a defined phase inside the frame.

The frame pulse is sampled on the rising edge of the bit clock and is one bit clock wide. A frame in which the pulse is missing does not count. Reset is asynchronous and active low.

Top module: `frame_sec_timer`

## Requirements
- R1: While reset is low, and on the first edge after it is released, `squareOut` and `statusBit` are 0. Every internal count also restarts from zero, so the first square-wave flip needs a full FRAMES_PER_HALF sampled pulses after reset.
- R2: A bit-clock edge that samples `framePulse` low does not advance the frame count. Missing pulses therefore only delay the next square-wave flip.
- R3: `squareOut` flips on the bit-clock edge that samples every FRAMES_PER_HALF-th frame pulse since reset (4000 by default). It changes at no other edge.
- R4: `statusBit` flips only after a 0-to-1 transition of `squareOut`. A 1-to-0 transition of `squareOut` leaves `statusBit` unchanged.
- R5: `statusBit` flips exactly STATUS_DELAY bit-clock edges (62 by default) after the edge that sampled the pulse which made `squareOut` rise.
- R6: If reset is applied while a status flip is pending, the pending flip is cancelled. `statusBit` stays 0 until a new rise of `squareOut` has completed its delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Backplane bit clock (2.048 MHz by default) |
| rstN | input | 1 | Asynchronous reset, active low |
| framePulse | input | 1 | Frame pulse, one bit clock wide, sampled on the rising edge of bitClk |
| squareOut | output | 1 | Square wave that flips every FRAMES_PER_HALF frames |
| statusBit | output | 1 | Status bit that flips STATUS_DELAY bit clocks after each square-wave rise |

## Verification
The bench uses a small configuration: 4 frames per half period, a delay of 5 bit clocks and 8-bit frames. It compares both outputs on every bit clock against an arithmetic model that counts sampled pulses and rise times.

The stimulus covers five patterns:
- Regular frames, which fix the flip points and the delay.
- Frames with periodic gaps, which show that missing pulses do not count.
- Pulses on every bit clock, which put a falling square edge inside a pending delay and so separate rise-only behaviour from any-edge behaviour.
- Pseudo-random gaps.
- A reset applied during a pending delay, which shows that the pending flip is cancelled.

// File: rtl/frame_timer_pkg.sv
package frame_timer_pkg;
  typedef struct packed {
    logic flipSquare;
    logic flipStatus;
  } strobe_t;
endpackage

// File: rtl/frame_timer_ctrl.sv
module frame_timer_ctrl
  import frame_timer_pkg::*;
#(
  parameter int FRAMES_PER_HALF = 4000,
  parameter int STATUS_DELAY = 62
) (
  input  logic    bitClk,
  input  logic    rstN,
  input  logic    framePulse,
  input  logic    squareNow,
  output strobe_t strobes
);
  localparam int FCW = (FRAMES_PER_HALF > 1) ? $clog2(FRAMES_PER_HALF) : 1;
  localparam int DCW = (STATUS_DELAY > 1) ? $clog2(STATUS_DELAY) : 1;
  localparam logic [FCW-1:0] LAST_FRAME = FCW'(FRAMES_PER_HALF - 1);
  localparam logic [DCW-1:0] DELAY_LOAD = DCW'(STATUS_DELAY - 1);

  logic [FCW-1:0] frameCount;
  logic [DCW-1:0] delayCount;
  logic           armed;
  logic           wrap;

  assign wrap = framePulse && (frameCount == LAST_FRAME);

  // Frame counter: advances only on sampled pulses.
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      frameCount <= '0;
    end else if (framePulse) begin
      frameCount <= wrap ? '0 : frameCount + 1'b1;
    end
  end

  // Delay counter: armed by a wrap that makes the square wave rise.
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b0;
      delayCount <= '0;
    end else if (wrap && !squareNow) begin
      armed      <= 1'b1;
      delayCount <= DELAY_LOAD;
    end else if (armed) begin
      if (delayCount == '0) begin
        armed <= 1'b0;
      end else begin
        delayCount <= delayCount - 1'b1;
      end
    end
  end

  always_comb begin
    strobes.flipSquare = wrap;
    strobes.flipStatus = armed && (delayCount == '0);
  end
endmodule

// File: rtl/frame_timer_dp.sv
module frame_timer_dp
  import frame_timer_pkg::*;
(
  input  logic    bitClk,
  input  logic    rstN,
  input  strobe_t strobes,
  output logic    squareOut,
  output logic    statusBit
);
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      squareOut <= 1'b0;
      statusBit <= 1'b0;
    end else begin
      if (strobes.flipSquare) squareOut <= ~squareOut;
      if (strobes.flipStatus) statusBit <= ~statusBit;
    end
  end
endmodule

// File: rtl/frame_sec_timer.sv
module frame_sec_timer #(
  parameter int BITS_PER_FRAME = 256,
  parameter int FRAMES_PER_HALF = 4000,
  parameter int STATUS_DELAY = 62
) (
  input  logic bitClk,
  input  logic rstN,
  input  logic framePulse,
  output logic squareOut,
  output logic statusBit
);
  import frame_timer_pkg::*;

  strobe_t strobes;

  // The delay must end before the next square-wave edge can arrive.
  if (STATUS_DELAY < 1 || STATUS_DELAY >= FRAMES_PER_HALF * BITS_PER_FRAME
      || FRAMES_PER_HALF < 2) begin : g_bad_cfg
    $error("frame_sec_timer: unsupported parameter combination");
  end

  frame_timer_ctrl #(
    .FRAMES_PER_HALF(FRAMES_PER_HALF),
    .STATUS_DELAY(STATUS_DELAY)
  ) u_ctrl (
    .bitClk(bitClk),
    .rstN(rstN),
    .framePulse(framePulse),
    .squareNow(squareOut),
    .strobes(strobes)
  );

  frame_timer_dp u_dp (
    .bitClk(bitClk),
    .rstN(rstN),
    .strobes(strobes),
    .squareOut(squareOut),
    .statusBit(statusBit)
  );
endmodule

// File: rtl/frame_sec_timer_checker.sv
module frame_sec_timer_checker #(
  parameter int STATUS_DELAY = 62
) (
  input logic bitClk,
  input logic rstN,
  input logic framePulse,
  input logic squareOut,
  input logic statusBit
);
  localparam int SCW = $clog2(STATUS_DELAY + 2);
  localparam logic [SCW-1:0] SAT = SCW'(STATUS_DELAY + 1);
  localparam logic [SCW-1:0] DLY = SCW'(STATUS_DELAY);

  logic           prevSquare;
  logic           prevStatus;
  logic [SCW-1:0] sinceRise;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      prevSquare <= 1'b0;
      prevStatus <= 1'b0;
      sinceRise  <= SAT;
    end else begin
      prevSquare <= squareOut;
      prevStatus <= statusBit;
      if (squareOut && !prevSquare) sinceRise <= SCW'(1);
      else if (sinceRise != SAT) sinceRise <= sinceRise + 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge bitClk)
    $rose(rstN) |-> (!squareOut && !statusBit));

  assert_no_pulse_hold_R2: assert property (@(posedge bitClk) disable iff (!rstN)
    !framePulse |=> (squareOut == $past(squareOut)));

  assert_square_on_pulse_R3: assert property (@(posedge bitClk) disable iff (!rstN)
    (squareOut != prevSquare) |-> $past(framePulse));

  assert_status_after_rise_R4: assert property (@(posedge bitClk) disable iff (!rstN)
    (statusBit != prevStatus) |-> (sinceRise != SAT));

  assert_status_delay_R5: assert property (@(posedge bitClk) disable iff (!rstN)
    (statusBit != prevStatus) |-> (sinceRise == DLY));
endmodule

bind frame_sec_timer frame_sec_timer_checker #(.STATUS_DELAY(STATUS_DELAY)) u_checker (
  .bitClk(bitClk),
  .rstN(rstN),
  .framePulse(framePulse),
  .squareOut(squareOut),
  .statusBit(statusBit)
);

// File: tb/frame_sec_timer_bench.sv
module frame_sec_timer_bench;
  localparam int BPF = 8;
  localparam int NHALF = 4;
  localparam int DLY = 5;

  logic bitClk = 1'b0;
  logic rstN = 1'b0;
  logic framePulse = 1'b0;
  logic squareOut, statusBit;

  int compared = 0;
  int mismatched = 0;
  int pulses = 0;
  int cyc = 0;
  int riseCount = 0;
  int riseCyc = -1000;
  logic [7:0] lfsr = 8'hA5;

  always #4 bitClk = ~bitClk;

  frame_sec_timer #(
    .BITS_PER_FRAME(BPF),
    .FRAMES_PER_HALF(NHALF),
    .STATUS_DELAY(DLY)
  ) u_frame_sec_timer (
    .bitClk(bitClk),
    .rstN(rstN),
    .framePulse(framePulse),
    .squareOut(squareOut),
    .statusBit(statusBit)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at t=%0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic expSq, expSt;
    int done;
    expSq = ((pulses / NHALF) % 2) == 1;
    done = riseCount - ((riseCount > 0 && cyc < riseCyc + DLY) ? 1 : 0);
    expSt = (done % 2) == 1;
    check(tag, squareOut, expSq, "squareOut");
    check(tag, statusBit, expSt, "statusBit");
  endtask

  // Drive one bit clock at the falling edge, then model the rising edge.
  task automatic step(input logic p, input string tag);
    framePulse = p;
    @(posedge bitClk);
    #1;
    if (rstN) begin
      cyc++;
      if (p) begin
        pulses++;
        if (pulses % (2 * NHALF) == NHALF) begin
          riseCount++;
          riseCyc = cyc;
        end
      end
    end
    @(negedge bitClk);
    compareAll(tag);
  endtask

  task automatic doReset(input int n, input string tag);
    rstN = 1'b0;
    pulses = 0;
    riseCount = 0;
    riseCyc = -1000;
    #1;
    check(tag, squareOut, 1'b0, "squareOut in reset");
    check(tag, statusBit, 1'b0, "statusBit in reset");
    for (int i = 0; i < n; i++) step(1'b1, tag);
    rstN = 1'b1;
  endtask

  initial begin
    #1600000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge bitClk);
    // R1: outputs clear during reset while pulses are applied.
    doReset(4, "R1");
    // R3, R5: regular frames
    for (int f = 0; f < 3 * 2 * NHALF; f++)
      for (int b = 0; b < BPF; b++) step(b == 0, "R3/R5");
    // R2: every third frame has no pulse
    for (int f = 0; f < 30; f++)
      for (int b = 0; b < BPF; b++) step(b == 0 && (f % 3) != 2, "R2");
    // R4: pulse on every bit clock, the falling edge lands inside the delay
    for (int i = 0; i < 100; i++) step(1'b1, "R4");
    // R2/R5: pseudo-random gaps
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] & lfsr[2], "R2");
    end
    // R6: reset while a status flip is pending
    doReset(2, "R6");
    for (int i = 0; i < NHALF; i++) step(1'b1, "R6");
    step(1'b0, "R6");
    doReset(3, "R6");
    for (int i = 0; i < 2 * DLY; i++) step(1'b0, "R6");
    for (int f = 0; f < 4 * NHALF; f++)
      for (int b = 0; b < BPF; b++) step(b == 0, "R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule